// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt and Wake Unit

This block watches a set of general-purpose input pins and turns activity on them into interrupt and wake requests. Each pin is set to one of two modes. In edge mode it reacts to a rising transition, a falling transition, or both. In level mode it reacts while the pin sits at a chosen active level, which may be high or low. Detected events are captured in a sticky status bit. Software clears that bit by writing a one to it.

Pins are grouped in banks of 32. Every bank has its own set of configuration and status words behind a simple single-cycle write port and a combinational read port. An interrupt mask decides which captured events drive the single combined interrupt line. A separate wake mask copies events into a wake status word. Any set bit in that wake status word raises the wake request line.

Pin inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized value with the synchronized value from one clock earlier.

Top module: `gpio_irq_wake_unit`

## Requirements
- R1: After reset, every configuration word and every status word in every bank reads zero, and `irq_out` and `wake_out` are low.
- R2: With its rising-enable bit set, a pin that goes from 0 to 1 sets its interrupt-status bit. The input is sampled at clock edge k and the status bit reads 1 after edge k+2. A falling transition on a pin whose falling-enable bit is clear sets nothing.
- R3: A falling transition sets the status bit when the falling-enable bit is set. With both enable bits set, either transition sets it.
- R4: A level-select bit of 1 puts a pin in level mode. With its active-low bit at 0, the status bit is set again every cycle while the synchronized pin is high. A clear written during that time has no effect. Once the pin is low, the latched bit stays set until it is cleared.
- R5: In level mode, an active-low bit of 1 makes the pin active while it is low.
- R6: Software may program the active-low bit and then switch a pin to level mode while the pin is at its inactive level. Doing so creates no event. In level mode the edge-enable bits have no effect. A status bit only becomes set when an event is detected.
- R7: Writing a 1 to an interrupt-status bit clears that bit. Writing a 0 leaves the bit unchanged.
- R8: If an event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R9: The status bit is captured whatever the interrupt-mask bit holds. `irq_out` is the OR, over all banks, of (status AND mask). A mask bit of 1 enables its pin.
- R10: A wake-status bit sets when an event occurs on a pin whose wake-mask bit is 1. Writing a 1 to a wake-status bit clears it. `wake_out` is the OR of all wake-status bits.
- R11: The word address is {region[2:0], bank}. The region codes are: 0 rising enable, 1 falling enable, 2 level select, 3 active low, 4 interrupt mask, 5 interrupt status, 6 wake mask, 7 wake status. Configuration words read back as written. Pin 32·b+i maps to bit i of bank b. Banks do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address {region, bank} |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word address {region, bank} |
| rd_data | output | 32 | Combinational read data |
| irq_out | output | 1 | Combined masked interrupt |
| wake_out | output | 1 | Combined wake request |

## Verification
Edge detection is driven with a lone rising edge, a lone falling edge, and both edges on a pin that has both enables set. These patterns show whether each enable bit gates only its own direction. Level mode is driven with a held active level, first high-active and then low-active, while clears are written. This separates a status bit that re-asserts each cycle from one that latches only once. A mode switch is made with the pin already at its inactive level, and a clear is timed to land on the same edge as a fresh event. These expose spurious events and a wrong priority between event and clear. Pins in both banks are exercised, together with masked and unmasked pins, to tell the captured status apart from the gated interrupt and wake outputs.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int BANK_W = 32;

    typedef enum logic [2:0] {
        RG_RISE   = 3'd0,
        RG_FALL   = 3'd1,
        RG_LEVEL  = 3'd2,
        RG_LOWACT = 3'd3,
        RG_IMASK  = 3'd4,
        RG_ISTAT  = 3'd5,
        RG_WMASK  = 3'd6,
        RG_WSTAT  = 3'd7
    } region_e;

    typedef struct packed {
        logic [BANK_W-1:0] rise_en;
        logic [BANK_W-1:0] fall_en;
        logic [BANK_W-1:0] level_sel;
        logic [BANK_W-1:0] low_act;
        logic [BANK_W-1:0] irq_mask;
        logic [BANK_W-1:0] irq_stat;
        logic [BANK_W-1:0] wake_mask;
        logic [BANK_W-1:0] wake_stat;
    } bank_regs_t;

endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_now,
    output logic [W-1:0] pin_prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] now;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_async;
        s_d.now  = s_q.meta;
        s_d.prev = s_q.now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_now  = s_q.now;
    assign pin_prev = s_q.prev;

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pin_now,
    input  logic [BANK_W-1:0] pin_prev,
    input  logic              wr_hit,
    input  region_e           wr_region,
    input  logic [BANK_W-1:0] wr_data,
    output bank_regs_t        regs_o,
    output logic              irq_o,
    output logic              wake_o
);

    bank_regs_t regs_d, regs_q;
    logic [BANK_W-1:0] rise_det, fall_det, lvl_hit, edge_hit, evt;
    logic [BANK_W-1:0] clr_irq, clr_wake;

    always_comb begin
        rise_det = pin_now & ~pin_prev;
        fall_det = ~pin_now & pin_prev;
        lvl_hit  = pin_now ^ regs_q.low_act;
        edge_hit = (rise_det & regs_q.rise_en) | (fall_det & regs_q.fall_en);
        evt      = ((regs_q.level_sel & lvl_hit) | (~regs_q.level_sel & edge_hit)) & VALID;

        clr_irq  = (wr_hit && wr_region == RG_ISTAT) ? wr_data : '0;
        clr_wake = (wr_hit && wr_region == RG_WSTAT) ? wr_data : '0;

        regs_d = regs_q;
        if (wr_hit) begin
            case (wr_region)
                RG_RISE:   regs_d.rise_en   = wr_data & VALID;
                RG_FALL:   regs_d.fall_en   = wr_data & VALID;
                RG_LEVEL:  regs_d.level_sel = wr_data & VALID;
                RG_LOWACT: regs_d.low_act   = wr_data & VALID;
                RG_IMASK:  regs_d.irq_mask  = wr_data & VALID;
                RG_WMASK:  regs_d.wake_mask = wr_data & VALID;
                default:   ;
            endcase
        end
        regs_d.irq_stat  = (regs_q.irq_stat & ~clr_irq) | evt;
        regs_d.wake_stat = (regs_q.wake_stat & ~clr_wake) | (evt & regs_q.wake_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
    assign irq_o  = |(regs_q.irq_stat & regs_q.irq_mask);
    assign wake_o = |regs_q.wake_stat;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.irq_stat & $past(clr_irq & ~evt)) == '0)); // R7

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.irq_stat & $past(evt)) == $past(evt))); // R8

    AST_WAKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.wake_stat & $past(evt & regs_q.wake_mask)) == $past(evt & regs_q.wake_mask))); // R10

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((regs_q.irq_stat & ~$past(regs_q.irq_stat) & ~$past(evt)) == '0)); // R6

endmodule

// File: rtl/gpio_irq_wake_unit.sv
`timescale 1ns/1ps
module gpio_irq_wake_unit
    import gpio_irq_pkg::*;
#(
    parameter  int NUM_PINS   = 64,
    localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
    localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W     = 3 + BANK_IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BANK_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BANK_W-1:0]   rd_data,
    output logic                irq_out,
    output logic                wake_out
);

    localparam int PAD_W = NUM_BANKS * BANK_W;

    logic [PAD_W-1:0]      pin_pad;
    logic [PAD_W-1:0]      pin_now, pin_prev;
    bank_regs_t            regs_a [NUM_BANKS];
    logic [NUM_BANKS-1:0]  irq_vec, wake_vec;
    region_e               wr_region, rd_region;
    logic [BANK_IDX_W-1:0] wr_bank, rd_bank;

    always_comb begin
        pin_pad                 = '0;
        pin_pad[NUM_PINS-1:0]   = pin_in;
    end

    assign wr_region = region_e'(wr_addr[ADDR_W-1 -: 3]);
    assign rd_region = region_e'(rd_addr[ADDR_W-1 -: 3]);
    assign wr_bank   = wr_addr[BANK_IDX_W-1:0];
    assign rd_bank   = rd_addr[BANK_IDX_W-1:0];

    gpio_pin_sync #(.W(PAD_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_pad),
        .pin_now   (pin_now),
        .pin_prev  (pin_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LIVE = ((NUM_PINS - b * BANK_W) >= BANK_W) ? BANK_W : (NUM_PINS - b * BANK_W);
        localparam logic [BANK_W-1:0] VMASK = (LIVE == BANK_W) ? '1 : ((BANK_W'(1) << LIVE) - BANK_W'(1));

        gpio_irq_bank #(.VALID(VMASK)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_now   (pin_now[b*BANK_W +: BANK_W]),
            .pin_prev  (pin_prev[b*BANK_W +: BANK_W]),
            .wr_hit    (wr_en && (wr_bank == BANK_IDX_W'(b))),
            .wr_region (wr_region),
            .wr_data   (wr_data),
            .regs_o    (regs_a[b]),
            .irq_o     (irq_vec[b]),
            .wake_o    (wake_vec[b])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_bank == BANK_IDX_W'(b)) begin
                case (rd_region)
                    RG_RISE:   rd_data = regs_a[b].rise_en;
                    RG_FALL:   rd_data = regs_a[b].fall_en;
                    RG_LEVEL:  rd_data = regs_a[b].level_sel;
                    RG_LOWACT: rd_data = regs_a[b].low_act;
                    RG_IMASK:  rd_data = regs_a[b].irq_mask;
                    RG_ISTAT:  rd_data = regs_a[b].irq_stat;
                    RG_WMASK:  rd_data = regs_a[b].wake_mask;
                    default:   rd_data = regs_a[b].wake_stat;
                endcase
            end
        end
    end

    assign irq_out  = |irq_vec;
    assign wake_out = |wake_vec;

endmodule

// File: tb/tb_gpio_irq_wake_unit.sv
`timescale 1ns/1ps
module tb_gpio_irq_wake_unit;

    localparam int RISE = 0, FALL = 1, LEVEL = 2, LOWACT = 3;
    localparam int IMASK = 4, ISTAT = 5, WMASK = 6, WSTAT = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_out, wake_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_wake_unit #(.NUM_PINS(64)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    function automatic logic [3:0] ad(input int region, input int bank);
        return {3'(region), 1'(bank)};
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input int region, input int bank, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad(region, bank); wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int region, input int bank, output logic [31:0] data);
        rd_addr = ad(region, bank);
        #1;
        data = rd_data;
    endtask

    task automatic set_pin(input int idx, input logic val);
        @(negedge clk);
        pins[idx] = val;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stat_bit(input int bank, input int bit_i, input logic exp, input string tag);
        logic [31:0] v;
        rd(ISTAT, bank, v);
        chk(32'(v[bit_i]), 32'(exp), tag);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 8; r++) begin
                rd(r, b, v);
                chk(v, 32'h0, "R1 register after reset");
            end
        chk(32'(irq_out), 0, "R1 irq_out after reset");
        chk(32'(wake_out), 0, "R1 wake_out after reset");
    endtask

    task automatic t_rising;
        wr(RISE, 0, 32'h1);
        wr(IMASK, 0, 32'h1);
        set_pin(0, 1'b1);
        stat_bit(0, 0, 1'b1, "R2 rising edge captured");
        chk(32'(irq_out), 1, "R2 irq after rising edge");
        wr(ISTAT, 0, 32'h1);
        stat_bit(0, 0, 1'b0, "R7 write one clears");
        chk(32'(irq_out), 0, "R7 irq low after clear");
        set_pin(0, 1'b0);
        stat_bit(0, 0, 1'b0, "R2 falling edge ignored without enable");
        set_pin(0, 1'b1);
        wr(ISTAT, 0, 32'h0);
        stat_bit(0, 0, 1'b1, "R7 write zero keeps bit");
        wr(ISTAT, 0, 32'h1);
        set_pin(0, 1'b0);
        wr(RISE, 0, 32'h0);
        wr(IMASK, 0, 32'h0);
    endtask

    task automatic t_edges;
        wr(RISE, 0, 32'h2);
        wr(FALL, 0, 32'h6);
        set_pin(1, 1'b1);
        stat_bit(0, 1, 1'b1, "R3 both-edge pin on rise");
        wr(ISTAT, 0, 32'h2);
        set_pin(1, 1'b0);
        stat_bit(0, 1, 1'b1, "R3 both-edge pin on fall");
        wr(ISTAT, 0, 32'h2);
        set_pin(2, 1'b1);
        stat_bit(0, 2, 1'b0, "R3 fall-only pin ignores rise");
        set_pin(2, 1'b0);
        stat_bit(0, 2, 1'b1, "R3 fall-only pin on fall");
        wr(ISTAT, 0, 32'h4);
        wr(RISE, 0, 32'h0);
        wr(FALL, 0, 32'h0);
    endtask

    task automatic t_level_high;
        set_pin(3, 1'b1);
        stat_bit(0, 3, 1'b0, "R2 no event without enables");
        wr(LEVEL, 0, 32'h8);
        @(posedge clk); @(negedge clk);
        stat_bit(0, 3, 1'b1, "R4 active-high level captured");
        wr(ISTAT, 0, 32'h8);
        stat_bit(0, 3, 1'b1, "R8 clear loses to held level");
        set_pin(3, 1'b0);
        stat_bit(0, 3, 1'b1, "R4 latched after level drops");
        wr(ISTAT, 0, 32'h8);
        stat_bit(0, 3, 1'b0, "R4 clear after level drops");
        wr(LEVEL, 0, 32'h0);
    endtask

    task automatic t_level_low;
        set_pin(4, 1'b1);
        wr(RISE, 0, 32'h10);
        wr(FALL, 0, 32'h10);
        wr(ISTAT, 0, 32'h10);
        wr(LOWACT, 0, 32'h10);
        wr(LEVEL, 0, 32'h10);
        repeat (3) @(posedge clk);
        @(negedge clk);
        stat_bit(0, 4, 1'b0, "R6 mode switch at inactive level");
        set_pin(4, 1'b0);
        stat_bit(0, 4, 1'b1, "R5 active-low level captured");
        set_pin(4, 1'b1);
        wr(ISTAT, 0, 32'h10);
        stat_bit(0, 4, 1'b0, "R6 edge enables ignored in level mode");
        wr(LEVEL, 0, 32'h0);
        wr(LOWACT, 0, 32'h0);
        wr(RISE, 0, 32'h0);
        wr(FALL, 0, 32'h0);
        set_pin(4, 1'b0);
        wr(ISTAT, 0, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask;
        wr(RISE, 0, 32'h20);
        set_pin(5, 1'b1);
        stat_bit(0, 5, 1'b1, "R9 status captured while masked");
        chk(32'(irq_out), 0, "R9 irq blocked by mask");
        wr(IMASK, 0, 32'h20);
        chk(32'(irq_out), 1, "R9 irq after unmask");
        wr(ISTAT, 0, 32'h20);
        chk(32'(irq_out), 0, "R9 irq low after clear");
        wr(IMASK, 0, 32'h0);
        wr(RISE, 0, 32'h0);
        set_pin(5, 1'b0);
    endtask

    task automatic t_wake;
        logic [31:0] v;
        wr(RISE, 0, 32'hC0);
        wr(WMASK, 0, 32'h40);
        set_pin(7, 1'b1);
        rd(WSTAT, 0, v);
        chk(v, 32'h0, "R10 no wake without wake mask");
        chk(32'(wake_out), 0, "R10 wake_out low");
        set_pin(6, 1'b1);
        rd(WSTAT, 0, v);
        chk(v, 32'h40, "R10 wake status set");
        chk(32'(wake_out), 1, "R10 wake_out high");
        wr(WSTAT, 0, 32'h40);
        rd(WSTAT, 0, v);
        chk(v, 32'h0, "R10 wake status cleared");
        chk(32'(wake_out), 0, "R10 wake_out low after clear");
        wr(ISTAT, 0, 32'hC0);
        wr(WMASK, 0, 32'h0);
        wr(RISE, 0, 32'h0);
        set_pin(6, 1'b0);
        set_pin(7, 1'b0);
    endtask

    task automatic t_bank1;
        logic [31:0] v;
        wr(RISE, 1, 32'h100);
        wr(IMASK, 1, 32'h100);
        rd(RISE, 1, v);
        chk(v, 32'h100, "R11 bank 1 config readback");
        rd(RISE, 0, v);
        chk(v, 32'h0, "R11 bank 0 untouched by bank 1 write");
        set_pin(40, 1'b1);
        rd(ISTAT, 1, v);
        chk(v, 32'h100, "R11 pin 40 maps to bank 1 bit 8");
        rd(ISTAT, 0, v);
        chk(v, 32'h0, "R11 bank 0 status untouched");
        chk(32'(irq_out), 1, "R9 irq from bank 1");
        wr(ISTAT, 1, 32'h100);
        wr(IMASK, 1, 32'h0);
        wr(RISE, 1, 32'h0);
        set_pin(40, 1'b0);
    endtask

    task automatic t_race;
        wr(RISE, 0, 32'h200);
        set_pin(9, 1'b1);
        set_pin(9, 1'b0);
        stat_bit(0, 9, 1'b1, "R8 first rising edge");
        @(negedge clk);
        pins[9] = 1'b1;
        repeat (2) @(posedge clk);
        wr(ISTAT, 0, 32'h200);
        stat_bit(0, 9, 1'b1, "R8 event beats same-cycle clear");
        wr(ISTAT, 0, 32'h200);
        stat_bit(0, 9, 1'b0, "R7 later clear works");
        wr(RISE, 0, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rising();
        t_edges();
        t_level_high();
        t_level_low();
        t_mask();
        t_wake();
        t_bank1();
        t_race();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule